// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval timer. It holds a binary period of up to 65536 ticks. The counter advances only on cycles where the count-enable input `tick` is high. The channel produces an output waveform chosen by a three-bit mode code: a one-shot that stays asserted after it expires, a retriggerable one-shot, a periodic rate pulse, a square wave, and two single-tick strobes, one started by software and one started by hardware.

A separate front end decodes register accesses and assembles the two bytes of a count. It presents this channel with a full 16-bit value and a mode code on the `load` strobe. It drives the gate level. It raises `snap` to copy the readable count into a holding register. The holding register keeps its value until the next request. The channel counts in binary only and reports no pending-count status.

Top module: `interval_chan`

## Requirements
- R1: A loaded value of 0 acts as a period of 65536. After one counted tick in a non-periodic mode, the readable count is 0xFFFF.
- R2: Mode 0: `out` is low after a load. It goes high once N ticks have been counted and stays high until the next load.
- R3: Mode 1: a load leaves `out` high and the counter idle. A gate rising edge drives `out` low and starts counting. `out` returns high after N counted ticks.
- R4: Mode 2: `out` is high exactly when the number of counted ticks is a nonzero multiple of N. The period repeats without a new load.
- R5: Mode 3: with e counted ticks, `out` is high while (e mod N) < (N+1)/2. The readable count is N − (2e mod N), taken to 16 bits.
- R6: Modes 4 and 5: `out` is high only while the counted ticks equal N. Mode 4 counts from the load. Mode 5 counts from a gate rising edge.
- R7: A gate rising edge in modes 1, 2, 3 and 5 restarts the count from the loaded period, with zero ticks counted.
- R8: A low gate stops counting in modes 0, 2, 3 and 4. Modes 1 and 5 keep counting whatever the gate level.
- R9: In modes 0, 1, 4 and 5 the readable count is (N − e) mod 65536. In mode 2 it is N − (e mod N), taken to 16 bits. A `snap` pulse copies the readable count, as it stands before that edge, to `snap_count`. `snap_count` does not change while `snap` is low.
- R10: After reset the channel is in mode 3 with a period of 65536, `out` is high and `snap_count` is 0.
- R11: Mode codes 6 and 7 behave exactly like codes 2 and 3.
- R12: When `load` coincides with a gate rising edge and a tick, the load wins: the new period and mode take effect with zero ticks counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count-enable pulse |
| gate | input | 1 | Gate level; a rising edge triggers or restarts, depending on the mode |
| load | input | 1 | Takes `load_val` and `mode_sel` and restarts the channel |
| load_val | input | 16 | Period value; 0 means 65536 |
| mode_sel | input | 3 | Mode code captured on `load` |
| snap | input | 1 | Copies the readable count to `snap_count` |
| out | output | 1 | Channel output waveform |
| snap_count | output | 16 | Count captured by the last `snap` |

## Verification
In one cycle a load can coincide with a gate rising edge and a tick, and a snapshot can coincide with the final tick of a period. The bench provokes both through directed steps and through a long randomized stretch that drives load, gate, tick and snap independently. A behavioural model keeps an elapsed-tick integer per load and derives each waveform from modular arithmetic. Each clock it is compared against `out` and `snap_count`, so a wrong priority shows up as an elapsed-count mismatch in the following cycles.

// File: rtl/tmr_pkg.sv
// Shared mode encoding for the interval counter channel.
// Assumes codes 6 and 7 are folded onto 2 and 3 before use.
package tmr_pkg;
    typedef enum logic [2:0] {
        M_ONESHOT = 3'd0,
        M_RETRIG  = 3'd1,
        M_RATE    = 3'd2,
        M_SQUARE  = 3'd3,
        M_SWSTB   = 3'd4,
        M_HWSTB   = 3'd5
    } tmr_mode_e;
endpackage

// File: rtl/chan_core.sv
// Remaining-tick register with periodic reload and terminal flags.
// Assumes start and adv are computed by the parent; start has priority.
module chan_core #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W:0]     start_period,
    input  logic           start_run,
    input  logic           adv,
    input  logic           periodic,
    input  logic [W:0]     period,
    output logic [W:0]     rem,
    output logic           done,
    output logic           pulse,
    output logic           run
);
    localparam int CW = W + 1;
    localparam logic [CW-1:0] FULL = CW'(1) << W;
    localparam logic [CW-1:0] ONE  = CW'(1);

    // Count down, reload in periodic modes, flag terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= FULL;
            done  <= 1'b0;
            pulse <= 1'b0;
            run   <= 1'b1;
        end else if (start) begin
            rem   <= start_period;
            done  <= 1'b0;
            pulse <= 1'b0;
            run   <= start_run;
        end else if (adv) begin
            if (periodic) begin
                if (rem == ONE) begin
                    rem   <= period;
                    pulse <= 1'b1;
                end else begin
                    rem   <= rem - ONE;
                    pulse <= 1'b0;
                end
            end else begin
                rem <= rem - ONE;
                if (rem == ONE && !done) begin
                    done  <= 1'b1;
                    pulse <= 1'b1;
                end else begin
                    pulse <= 1'b0;
                end
            end
        end
    end

    // R2: terminal flag stays set until the next start
    p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);
endmodule

// File: rtl/chan_wave.sv
// Decodes output level and readable count from the core state per mode.
// Assumes mode is already folded to 0..5 and period is 1..2^W.
module chan_wave
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  tmr_mode_e      mode,
    input  logic [W:0]     period,
    input  logic [W:0]     rem,
    input  logic           done,
    input  logic           pulse,
    input  logic           run,
    output logic           out,
    output logic [W-1:0]   readout
);
    localparam int CW = W + 1;

    logic [CW-1:0] elapsed_ph;
    logic [CW:0]   dbl;
    logic [CW:0]   dbl_mod;

    // Square-wave readout: count drops by two per tick within the period.
    always_comb begin
        elapsed_ph = period - rem;
        dbl        = {elapsed_ph, 1'b0};
        dbl_mod    = (dbl >= {1'b0, period}) ? dbl - {1'b0, period} : dbl;
    end

    // Select output level and count view for the active mode.
    always_comb begin
        case (mode)
            M_ONESHOT: out = done;
            M_RETRIG:  out = done | ~run;
            M_RATE:    out = pulse;
            M_SQUARE:  out = rem > (period >> 1);
            default:   out = pulse;
        endcase
        if (mode == M_SQUARE)
            readout = W'(period - CW'(dbl_mod));
        else
            readout = W'(rem);
    end
endmodule

// File: rtl/interval_chan.sv
// One interval counter channel: mode/period capture, gate edge handling,
// count enable and snapshot register around the core and wave decoder.
// Assumes a front end supplies full 16-bit values and single-cycle strobes.
module interval_chan
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           gate,
    input  logic           load,
    input  logic [W-1:0]   load_val,
    input  logic [2:0]     mode_sel,
    input  logic           snap,
    output logic           out,
    output logic [W-1:0]   snap_count
);
    localparam int CW = W + 1;
    localparam logic [CW-1:0] FULL = CW'(1) << W;

    tmr_mode_e     mode_q, mode_new;
    logic [CW-1:0] period_q, load_norm, start_period, rem;
    logic          gate_q, rise, trig_cur, trig_new, restart, start, start_run, adv;
    logic          periodic, done, pulse, run;
    logic [W-1:0]  readout;

    // Fold load value and mode code into their internal forms.
    always_comb begin
        load_norm = (load_val == '0) ? FULL : {1'b0, load_val};
        mode_new  = tmr_mode_e'((mode_sel[2:1] == 2'b11) ? {1'b0, mode_sel[1:0]} : mode_sel);
        trig_new  = (mode_new == M_RETRIG) || (mode_new == M_HWSTB);
        trig_cur  = (mode_q == M_RETRIG) || (mode_q == M_HWSTB);
        periodic  = (mode_q == M_RATE) || (mode_q == M_SQUARE);
    end

    // Decide restart, start parameters and whether this cycle counts.
    always_comb begin
        rise         = gate & ~gate_q;
        restart      = rise & (trig_cur | periodic);
        start        = load | restart;
        start_period = load ? load_norm : period_q;
        start_run    = load ? ~trig_new : 1'b1;
        adv          = tick & run & (gate | trig_cur);
    end

    // Capture mode, period and previous gate level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= M_SQUARE;
            period_q <= FULL;
            gate_q   <= 1'b0;
        end else begin
            gate_q <= gate;
            if (load) begin
                mode_q   <= mode_new;
                period_q <= load_norm;
            end
        end
    end

    chan_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .start(start), .start_period(start_period),
        .start_run(start_run), .adv(adv), .periodic(periodic), .period(period_q),
        .rem(rem), .done(done), .pulse(pulse), .run(run)
    );

    chan_wave #(.W(W)) u_wave (
        .mode(mode_q), .period(period_q), .rem(rem), .done(done),
        .pulse(pulse), .run(run), .out(out), .readout(readout)
    );

    // Hold the readable count captured on a snapshot request.
    always_ff @(posedge clk) begin
        if (!rst_n) snap_count <= '0;
        else if (snap) snap_count <= readout;
    end

    // R12/R1: a load always installs the normalised value
    p_load_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> rem == $past(load_norm));
    // R7: gate rising edge in triggerable modes restarts from the period
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load && gate && !gate_q && (trig_cur || periodic) |=> rem == $past(period_q));
    // R8: low gate freezes the count in gated modes
    p_gate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !gate && !trig_cur |=> $stable(rem));
    // R9: snapshot register changes only on request
    p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(snap_count));
    // R4: periodic modes never leave the 1..N range
    p_period_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        periodic |-> (rem != '0) && (rem <= period_q));
endmodule

// File: tb/tb_interval_chan.sv
`timescale 1ns/1ps
module tb_interval_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, gate = 1'b0, load = 1'b0, snap = 1'b0;
    logic [15:0] load_val = '0;
    logic [2:0]  mode_sel = '0;
    logic        out;
    logic [15:0] snap_count;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    string ctx = "R10";

    // behavioural reference state
    int  m_n = 65536, m_mode = 3, m_el = 0, m_snap = 0;
    bit  m_run = 1, m_gq = 0;

    always #2.5 clk = ~clk;

    interval_chan dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .load(load),
        .load_val(load_val), .mode_sel(mode_sel), .snap(snap),
        .out(out), .snap_count(snap_count)
    );

    function automatic string mode_tag(int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic bit ref_out();
        case (m_mode)
            0: return m_el >= m_n;
            1: return !m_run || (m_el >= m_n);
            2: return (m_el > 0) && (m_el % m_n == 0);
            3: return (m_el % m_n) < ((m_n + 1) / 2);
            default: return m_run && (m_el == m_n);
        endcase
    endfunction

    function automatic int ref_read();
        case (m_mode)
            2: return (m_n - (m_el % m_n)) & 16'hFFFF;
            3: return (m_n - ((2 * m_el) % m_n)) & 16'hFFFF;
            default: return (m_n - m_el) & 16'hFFFF;
        endcase
    endfunction

    task automatic check(input bit got_o, input int got_c);
        bit eo;
        eo = ref_out();
        n_chk++;
        if (got_o !== eo) begin
            n_bad++;
            $display("FAIL %s (%s) out mode=%0d el=%0d got=%0b exp=%0b",
                     mode_tag(m_mode), ctx, m_mode, m_el, got_o, eo);
        end
        n_chk++;
        if (got_c != m_snap) begin
            n_bad++;
            $display("FAIL R9 (%s) snap_count got=%0h exp=%0h", ctx, got_c, m_snap);
        end
    endtask

    task automatic model_next(input bit t, input bit g, input bit l,
                              input int v, input int m, input bit s);
        bit rise;
        if (s) m_snap = ref_read();
        rise = g && !m_gq;
        m_gq = g;
        if (l) begin
            m_n    = (v == 0) ? 65536 : v;
            m_mode = (m >= 6) ? m - 4 : m;
            m_el   = 0;
            m_run  = !(m_mode == 1 || m_mode == 5);
        end else if (rise && m_mode inside {1, 2, 3, 5}) begin
            m_el  = 0;
            m_run = 1;
        end else if (t && m_run && (g || m_mode == 1 || m_mode == 5)) begin
            m_el++;
        end
    endtask

    // One cycle: check outputs, then drive inputs for the next edge.
    task automatic step(input bit t, input bit g, input bit l,
                        input int v, input int m, input bit s);
        @(negedge clk);
        check(out, int'(snap_count));
        tick = t; gate = g; load = l; load_val = v[15:0]; mode_sel = m[2:0]; snap = s;
        model_next(t, g, l, v, m, s);
    endtask

    task automatic run_n(input int n, input bit g, input bit s);
        for (int i = 0; i < n; i++) step(1'b1, g, 1'b0, 0, 0, s);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        @(negedge clk);
        check(out, int'(snap_count));          // R10 reset state
        rst_n = 1'b1;
        model_next(0, 0, 0, 0, 0, 0);
        run_n(4, 1'b1, 1'b1);                  // R10 default mode 3, 65536

        ctx = "R2";
        step(0, 1, 1, 5, 0, 1); run_n(8, 1'b1, 1'b1);
        ctx = "R8";
        step(0, 1, 1, 6, 0, 1); run_n(2, 1'b1, 1'b1); run_n(4, 1'b0, 1'b1); run_n(6, 1'b1, 1'b1);
        ctx = "R3";
        step(0, 0, 1, 4, 1, 1); run_n(3, 1'b0, 1'b1); run_n(2, 1'b1, 1'b1);
        run_n(2, 1'b0, 1'b1); run_n(7, 1'b1, 1'b1);
        ctx = "R4";
        step(0, 1, 1, 3, 2, 1); run_n(10, 1'b1, 1'b1);
        step(0, 1, 1, 1, 2, 1); run_n(4, 1'b1, 1'b1);
        ctx = "R5";
        step(0, 1, 1, 5, 3, 1); run_n(12, 1'b1, 1'b1);
        step(0, 1, 1, 4, 3, 1); run_n(10, 1'b1, 1'b1);
        ctx = "R6";
        step(0, 1, 1, 3, 4, 1); run_n(6, 1'b1, 1'b1);
        step(0, 0, 1, 3, 5, 1); run_n(2, 1'b0, 1'b1); run_n(6, 1'b1, 1'b1);
        ctx = "R7";
        step(0, 0, 1, 6, 2, 1); run_n(3, 1'b1, 1'b1); run_n(1, 1'b0, 1'b1); run_n(8, 1'b1, 1'b1);
        ctx = "R1";
        step(0, 1, 1, 0, 0, 1); run_n(3, 1'b1, 1'b1);
        ctx = "R11";
        step(0, 1, 1, 4, 6, 1); run_n(9, 1'b1, 1'b1);
        step(0, 1, 1, 5, 7, 1); run_n(9, 1'b1, 1'b1);
        ctx = "R12";
        step(0, 0, 1, 4, 2, 1);
        step(1, 1, 1, 3, 5, 1);                // load + rise + tick together
        run_n(6, 1'b1, 1'b0);                  // R9 snapshot held
        run_n(2, 1'b1, 1'b1);

        ctx = "mix";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            step($urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0, r < 4,
                 $urandom_range(0, 9), $urandom_range(0, 7), $urandom_range(0, 2) != 0);
        end
        @(negedge clk);
        check(out, int'(snap_count));
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule